// File: doc/BRIEF.md
# Strobe Watchdog with Status Pulse

This block watches a strobe line driven by running software. Each high-to-low transition of the strobe restarts a cycle counter. If the counter reaches its timeout before the next transition, the block drives an active-low status output for a fixed number of cycles. It then returns the output high and starts a new full timeout period.

The strobe is asynchronous to the block clock. It passes through a synchronizer chain before edge detection, so only a clean falling edge of the synchronized level counts as a restart. The system reset level, active low, clears the block and holds the status high. Timing starts from the release of reset. The timeout and the pulse width are parameters in clock cycles. With the defaults at a 125 MHz clock they give about one second and 130 ms.

Top module: `strobe_watchdog`

## Requirements
- R1: While `sys_rst_n_i` is low, `wd_stat_n_o` is high. Asserting reset during a status pulse drives the output high at once, without waiting for a clock edge.
- R2: After reset is released, if the strobe has no falling edge, `wd_stat_n_o` goes low at the TIMEOUT_CYC-th rising clock edge after the release.
- R3: A strobe change passes two synchronizing flops and one edge register. A strobe falling edge therefore takes effect at the third rising clock edge after the strobe falls. That edge restarts the count, and the next timeout falls TIMEOUT_CYC edges later.
- R4: A status pulse keeps `wd_stat_n_o` low for exactly PULSE_CYC clock cycles, after which the output returns high.
- R5: A strobe held steadily high, held steadily low, or rising from low to high never restarts the count.
- R6: Falling edges spaced TIMEOUT_CYC cycles apart or closer keep `wd_stat_n_o` high indefinitely. Falling edges spaced TIMEOUT_CYC+1 cycles apart let it fall.
- R7: When a pulse ends, a full TIMEOUT_CYC period starts at that edge. Strobe falling edges that arrive during a pulse neither shorten the pulse nor carry over into the next period.
- R8: A reset pulse applied in the middle of a status pulse ends the pulse. After the release, the block times a fresh period as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| sys_rst_n_i | input | 1 | System reset level, active low, asynchronous assert |
| strobe_i | input | 1 | Asynchronous strobe; a falling edge restarts the timeout |
| wd_stat_n_o | output | 1 | Watchdog status, low during a timeout pulse |

## Verification
The bench goes after the exact expiry edge. A design with an off-by-one counter or a missing synchronizer stage would drop the status one cycle early or late, and the per-cycle comparison would flag it. It drives strobe trains spaced at exactly the timeout and at one cycle more. A design that detected levels instead of edges, or compared against the wrong limit, would either never time out or time out while being serviced. It strobes during a pulse and asserts reset mid-pulse. A design that let a falling edge cut the pulse short, remembered that edge for the next period, or waited for a clock edge to release the output would show a wrong pulse width or a late return to high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    WD_TIMING = 1'b0,
    WD_PULSE  = 1'b1
  } wd_state_e;

  // Bits needed to count cycles 0 .. lim-1.
  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim <= 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/wdog_strobe_sync.sv
module wdog_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic strobe_i,
  output logic fall_o
);
  // chain_q[0 .. SYNC_STAGES-1] synchronize, chain_q[SYNC_STAGES] holds the previous level
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q[0] <= 1'b0;
    else          chain_q[0] <= strobe_i;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q[g] <= 1'b0;
      else          chain_q[g] <= chain_q[g-1];
    end
  end

  assign fall_o = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdog_cycle_ctr.sv
module wdog_cycle_ctr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  input  logic clr_i,
  output logic last_o
);
  localparam int unsigned CW = wdog_pkg::cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= at_end ? '0 : cnt_q + CW'(1);
  end

  assign last_o = run_i & at_end;
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 125_000_000,
  parameter int unsigned PULSE_CYC   = 16_250_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic sys_rst_n_i,
  input  logic strobe_i,
  output logic wd_stat_n_o
);
  wd_state_e state_q, state_d;
  logic kick_w;
  logic tmr_last_w;
  logic pls_last_w;
  logic in_pulse_w;

  assign in_pulse_w = (state_q == WD_PULSE);

  wdog_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i    (clk_i),
    .rst_n_i  (sys_rst_n_i),
    .strobe_i (strobe_i),
    .fall_o   (kick_w)
  );

  // Timeout counter: restarted by a kick, idle and cleared during a pulse.
  wdog_cycle_ctr #(.LIMIT(TIMEOUT_CYC)) tmr_i (
    .clk_i   (clk_i),
    .rst_n_i (sys_rst_n_i),
    .run_i   (~in_pulse_w),
    .clr_i   (kick_w | in_pulse_w),
    .last_o  (tmr_last_w)
  );

  // Pulse-width counter: only runs while the status is low.
  wdog_cycle_ctr #(.LIMIT(PULSE_CYC)) pls_i (
    .clk_i   (clk_i),
    .rst_n_i (sys_rst_n_i),
    .run_i   (in_pulse_w),
    .clr_i   (~in_pulse_w),
    .last_o  (pls_last_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_TIMING: if (tmr_last_w && !kick_w) state_d = WD_PULSE;
      WD_PULSE:  if (pls_last_w)            state_d = WD_TIMING;
      default:                              state_d = WD_TIMING;
    endcase
  end

  always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
    if (!sys_rst_n_i) state_q <= WD_TIMING;
    else              state_q <= state_d;
  end

  assign wd_stat_n_o = ~in_pulse_w;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned TIMEOUT_CYC = 16,
  parameter int unsigned PULSE_CYC   = 4
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic stat_n,
  input logic kick
);
  localparam int unsigned AW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [AW-1:0] since_arm;
  logic [PW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      since_arm <= AW'(1);
      low_run   <= '0;
    end else begin
      since_arm <= (!stat_n || kick) ? AW'(1) : since_arm + AW'(1);
      low_run   <= stat_n ? '0 : low_run + PW'(1);
    end
  end

  a_r1_reset_high: assert property (@(posedge clk_i)
    !rst_n_i |-> stat_n);

  a_r2_no_early_expiry: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (stat_n && since_arm < AW'(TIMEOUT_CYC)) |=> stat_n);

  a_r3_expire_after_arm: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (stat_n && !kick && since_arm == AW'(TIMEOUT_CYC)) |=> !stat_n);

  a_r4_pulse_not_short: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!stat_n && low_run < PW'(PULSE_CYC - 1)) |=> !stat_n);

  a_r4_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!stat_n && low_run == PW'(PULSE_CYC - 1)) |=> stat_n);
endmodule

bind strobe_watchdog wdog_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .PULSE_CYC   (PULSE_CYC)
) chk_i (
  .clk_i   (clk_i),
  .rst_n_i (sys_rst_n_i),
  .stat_n  (wd_stat_n_o),
  .kick    (kick_w)
);

// File: tb/strobe_watchdog_tb.sv
module strobe_watchdog_tb_top;
  localparam int T = 40;
  localparam int P = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b1;
  logic stat_n;

  always #4 clk = ~clk;

  strobe_watchdog #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) dut_i (
    .clk_i       (clk),
    .sys_rst_n_i (rst_n),
    .strobe_i    (strobe),
    .wd_stat_n_o (stat_n)
  );

  int errors = 0;
  int checks = 0;
  int low_seen = 0;
  string cur_req = "R1";

  // Behavioural reference: edge index, arm point, pulse window, strobe history
  int n = 0, last_arm = 0, pulse_end = 0;
  bit pulsing = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    n++;
    if (!rst_n) begin
      hist = '{0, 0, 0};
      pulsing = 0;
      last_arm = n;
    end else begin
      bit kick;
      kick = hist[0] && !hist[1];
      if (pulsing) begin
        if (n == pulse_end) begin
          pulsing = 0;
          last_arm = n;
        end
      end else if (kick) begin
        last_arm = n;
      end else if (n - last_arm == T) begin
        pulsing = 1;
        pulse_end = n + P;
      end
      void'(hist.pop_front());
      hist.push_back(strobe);
    end
    #3;
    checks++;
    if (stat_n !== !pulsing) begin
      errors++;
      $display("FAIL %s: cycle %0d stat_n=%0b expected %0b", cur_req, n, stat_n, !pulsing);
    end
    if (stat_n === 1'b0) low_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_check(input int wait_edges, input logic exp, input string req);
    repeat (wait_edges) @(posedge clk);
    #3;
    chk(stat_n === exp, req, int'(stat_n), int'(exp));
  endtask

  task automatic do_reset(input logic level);
    @(negedge clk);
    rst_n = 1'b0;
    strobe = level;
    cur_req = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    low_seen = 0;
  endtask

  task automatic kicks(input int gap, input int num);
    repeat (num) begin
      @(negedge clk) strobe = 1'b0;
      @(negedge clk) strobe = 1'b1;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  initial begin
    // R1: output high under reset while strobe toggles
    repeat (3) begin
      @(negedge clk) strobe = 1'b0;
      @(negedge clk) strobe = 1'b1;
    end
    edge_check(1, 1'b1, "R1");

    // R2, R4, R7: idle strobe after release
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R2";
    edge_check(T - 1, 1'b1, "R2");
    edge_check(1, 1'b0, "R2");
    cur_req = "R4";
    edge_check(P - 1, 1'b0, "R4");
    edge_check(1, 1'b1, "R4");
    cur_req = "R7";
    edge_check(T - 1, 1'b1, "R7");
    edge_check(1, 1'b0, "R7");
    // falling edges inside the pulse must be ignored
    @(negedge clk);
    kicks(2, 4);
    repeat (P + T + 10) @(posedge clk);

    // R3: regular service
    do_reset(1'b1);
    cur_req = "R3";
    kicks(25, 6);
    chk(low_seen == 0, "R3", low_seen, 0);

    // R6: spacing exactly the timeout, then one cycle more
    do_reset(1'b1);
    cur_req = "R6";
    kicks(T, 6);
    chk(low_seen == 0, "R6", low_seen, 0);
    do_reset(1'b1);
    cur_req = "R6";
    kicks(T + 1, 4);
    chk(low_seen > 0, "R6", low_seen, 1);

    // R5: steady low, then a single rise held high
    do_reset(1'b0);
    cur_req = "R5";
    edge_check(T - 1, 1'b1, "R5");
    edge_check(1, 1'b0, "R5");
    do_reset(1'b0);
    cur_req = "R5";
    @(negedge clk) strobe = 1'b1;
    repeat (T + 2) @(posedge clk);
    chk(low_seen > 0, "R5", low_seen, 1);

    // R8: reset in the middle of a pulse
    do_reset(1'b1);
    cur_req = "R8";
    while (stat_n !== 1'b0) @(posedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    cur_req = "R1";
    #1;
    chk(stat_n === 1'b1, "R8", int'(stat_n), 1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R8";
    edge_check(T - 1, 1'b1, "R8");
    edge_check(1, 1'b0, "R8");
    repeat (P + 2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: bench timed out, got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule